// File: doc/BRIEF.md
# LIN Protected Identifier Parity Checker

This block sits behind a LIN slave's byte receiver. After the sync field it takes the first byte that arrives, which is the protected identifier. It checks the two parity bits of that byte as the byte arrives. Every received byte goes to the receive FIFO write port, including the identifier.

When the sync field completes, the block pulses a pointer reset to the FIFO. The identifier byte therefore always lands in entry zero, and firmware finds it there.

A mismatch on either parity bit raises a sticky error flag, which firmware clears with a one-cycle pulse. Bytes after the identifier pass straight through to the FIFO and are not checked until the next sync.

Top module: `lin_pid_guard`

## Requirements
- R1: After a synchronous active-low reset, `fifo_wr_en`, `fifo_ptr_rst` and `pid_err` are 0. The block is not armed, so a byte received before any sync is not checked.
- R2: Each cycle with `rx_valid` high produces, one cycle later, `fifo_wr_en` = 1 with `fifo_wr_data` equal to `rx_data`. At all other times `fifo_wr_en` is 0.
- R3: A cycle with `sync_done` high produces, one cycle later, a single-cycle `fifo_ptr_rst` pulse.
- R4: The identifier byte holds ID0..ID5 in bits 0..5, P0 in bit 6 and P1 in bit 7. P0 must equal ID0 ^ ID1 ^ ID2 ^ ID4.
- R5: P1 must equal the inverse of ID1 ^ ID3 ^ ID4 ^ ID5. An identifier whose two parity bits both match does not set `pid_err`.
- R6: If the first byte after a sync has a parity mismatch, `pid_err` is 1 in the cycle after the byte. This is the same cycle in which that byte is written.
- R7: Only the first byte received after a sync is checked. Later bytes never set `pid_err`, whatever their bits 6 and 7 hold.
- R8: The identifier byte is written to the FIFO whether its parity is right or wrong.
- R9: `pid_err` stays at 1 until a cycle with `err_clr` high. It reads 0 in the following cycle, unless R10 applies.
- R10: If a new parity error and `err_clr` fall in the same cycle, the error wins and `pid_err` stays 1.
- R11: A byte in the same cycle as `sync_done` is written but not checked. The next byte is the one checked as the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_done | input | 1 | One-cycle strobe: the sync field has completed |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` is valid this cycle |
| err_clr | input | 1 | One-cycle clear of the parity error flag |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | Byte written to the FIFO |
| fifo_ptr_rst | output | 1 | FIFO address pointer reset pulse |
| pid_err | output | 1 | Sticky identifier parity error flag |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the error flag's set and clear. The bench first leaves the flag set. It then sends another sync, followed by a bad identifier in the same cycle as `err_clr`. The flag must still read 1 on the next cycle. A further clear on its own must then drop it.

The second pair is a sync strobe and a byte strobe in the same cycle. The bench sends a byte with bad parity together with `sync_done`. It expects that byte to be written with no error raised. It then expects the following bad byte to raise the flag.

// File: rtl/lin_pid_pkg.sv
// Package: shared types and the identifier parity function.
// Assumes the identifier layout: ID bits in [5:0], P0 in bit 6, P1 in bit 7.
package lin_pid_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 6;

    typedef logic [BYTE_W-1:0] pid_byte_t;
    typedef logic [ID_W-1:0]   pid_id_t;

    // Returns {P1, P0} computed from the six identifier bits.
    function automatic logic [1:0] pid_parity(input pid_id_t id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0};
    endfunction

endpackage

// File: rtl/pid_parity_calc.sv
// Combinational parity comparison of one received identifier byte.
// Assumes the byte is at least ID_W+2 bits wide, with the parity bits directly above the ID field.
module pid_parity_calc
    import lin_pid_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] byte_in,
    output logic              mismatch
);

    localparam int P_LO = ID_W;
    localparam int P_HI = ID_W + 1;

    logic [1:0] calc_par;
    logic [1:0] recv_par;

    // Compare the received parity pair against the computed pair.
    always_comb begin
        calc_par = pid_parity(byte_in[ID_W-1:0]);
        recv_par = {byte_in[P_HI], byte_in[P_LO]};
        mismatch = (calc_par != recv_par);
    end

    initial begin
        assert (DATA_W >= ID_W + 2)
            else $error("byte too narrow for identifier layout");
    end

endmodule

// File: rtl/pid_arm_ctrl.sv
// Arms after a sync strobe and selects the first byte that follows as the identifier.
// Assumes sync_done and rx_valid are single-cycle strobes. A byte in the same cycle
// as sync_done is treated as belonging to the previous frame.
module pid_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_done,
    input  logic rx_valid,
    output logic check_now
);

    logic armed;

    // Byte to be checked: first valid byte while armed and not in a sync cycle.
    always_comb begin
        check_now = armed && rx_valid && !sync_done;
    end

    // Armed state: set by sync, dropped by the byte that is checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (sync_done) begin
            armed <= 1'b1;
        end else if (rx_valid) begin
            armed <= 1'b0;
        end
    end

    // R7: once a byte has been checked, no further byte is checked until the next sync.
    p_single_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (check_now && !sync_done) |=> !check_now);

    // R11: a byte arriving together with sync is never the checked one.
    p_sync_byte_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_done && rx_valid) |-> !check_now);

endmodule

// File: rtl/pid_err_flag.sv
// Sticky parity error flag. A set takes priority over a clear in the same cycle.
// Assumes the set and clear inputs are synchronous to clk.
module pid_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Flag register: set wins, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // R10: a set always leaves the flag high, even with a concurrent clear.
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R9: with no clear and no set, the flag holds its value.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));

    // R9: a clear without a set drops the flag.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/lin_pid_guard.sv
// Top level: passes received bytes to the FIFO, resets FIFO pointers on sync,
// and flags a parity error on the first byte after each sync.
// Assumes a byte strobe of at most one byte per cycle and a FIFO that accepts every write.
module lin_pid_guard
    import lin_pid_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              err_clr,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              fifo_ptr_rst,
    output logic              pid_err
);

    logic check_now;
    logic mismatch;
    logic err_set;

    // Select which byte is the identifier.
    pid_arm_ctrl u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_done (sync_done),
        .rx_valid  (rx_valid),
        .check_now (check_now)
    );

    // Compute the parity mismatch of the incoming byte.
    pid_parity_calc #(.DATA_W(DATA_W)) u_par (
        .byte_in  (rx_data),
        .mismatch (mismatch)
    );

    // Raise the error only for the checked byte.
    always_comb begin
        err_set = check_now && mismatch;
    end

    // Hold the sticky error flag.
    pid_err_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .clr_i  (err_clr),
        .flag_o (pid_err)
    );

    // FIFO write port: register every received byte, parity good or bad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr_en   <= 1'b0;
            fifo_wr_data <= '0;
        end else begin
            fifo_wr_en <= rx_valid;
            if (rx_valid) begin
                fifo_wr_data <= rx_data;
            end
        end
    end

    // Pointer reset pulse: one cycle after each sync strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_ptr_rst <= 1'b0;
        end else begin
            fifo_ptr_rst <= sync_done;
        end
    end

    // R2: each valid byte is written one cycle later with the same data.
    p_write_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fifo_wr_en && fifo_wr_data == $past(rx_data)));

    // R2: no write without a byte.
    p_no_spurious_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fifo_wr_en);

    // R3: the pointer reset follows sync by one cycle.
    p_ptr_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |=> fifo_ptr_rst);

    // R3: the pointer reset lasts one cycle per sync.
    p_ptr_rst_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_done |=> !fifo_ptr_rst);

    // R6: a rising error flag coincides with the write of the offending byte.
    p_err_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pid_err) |-> fifo_wr_en);

endmodule

// File: tb/lin_pid_guard_test.sv
module lin_pid_guard_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_done;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       err_clr;
    logic       fifo_wr_en;
    logic [7:0] fifo_wr_data;
    logic       fifo_ptr_rst;
    logic       pid_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lin_pid_guard uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_done    (sync_done),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .err_clr      (err_clr),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data),
        .fifo_ptr_rst (fifo_ptr_rst),
        .pid_err      (pid_err)
    );

    function automatic logic [7:0] good_pid(input logic [5:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a negedge; return at the next negedge
    // with the registered results visible.
    task automatic step(input bit s, input bit v, input logic [7:0] d, input bit c);
        sync_done = s;
        rx_valid  = v;
        rx_data   = d;
        err_clr   = c;
        @(negedge clk);
        sync_done = 1'b0;
        rx_valid  = 1'b0;
        rx_data   = 8'h00;
        err_clr   = 1'b0;
    endtask

    task automatic t_reset();
        chk(fifo_wr_en == 1'b0, "R1 wr_en", fifo_wr_en, 0);
        chk(fifo_ptr_rst == 1'b0, "R1 ptr_rst", fifo_ptr_rst, 0);
        chk(pid_err == 1'b0, "R1 pid_err", pid_err, 0);
        // R1: byte before any sync is not checked
        step(0, 1, 8'h00, 0);
        chk(pid_err == 1'b0, "R1 unarmed byte", pid_err, 0);
        chk(fifo_wr_en && fifo_wr_data == 8'h00, "R2 unarmed write", fifo_wr_data, 0);
    endtask

    task automatic t_good_pid();
        logic [7:0] b;
        b = good_pid(6'h2A);
        step(1, 0, 8'h00, 0);
        chk(fifo_ptr_rst == 1'b1, "R3 ptr_rst pulse", fifo_ptr_rst, 1);
        step(0, 1, b, 0);
        chk(fifo_ptr_rst == 1'b0, "R3 ptr_rst single", fifo_ptr_rst, 0);
        chk(fifo_wr_en == 1'b1, "R2 wr_en", fifo_wr_en, 1);
        chk(fifo_wr_data == b, "R2 wr_data", fifo_wr_data, b);
        chk(pid_err == 1'b0, "R5 good pid no err", pid_err, 0);
        step(0, 0, 8'h00, 0);
        chk(fifo_wr_en == 1'b0, "R2 no write idle", fifo_wr_en, 0);
    endtask

    task automatic t_bad_p0();
        logic [7:0] b;
        b = good_pid(6'h15) ^ 8'h40;
        step(1, 0, 8'h00, 0);
        step(0, 1, b, 0);
        chk(pid_err == 1'b1, "R4 R6 bad P0", pid_err, 1);
        chk(fifo_wr_en && fifo_wr_data == b, "R8 bad pid written", fifo_wr_data, b);
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        chk(pid_err == 1'b1, "R9 flag holds", pid_err, 1);
        step(0, 0, 8'h00, 1);
        chk(pid_err == 1'b0, "R9 flag cleared", pid_err, 0);
    endtask

    task automatic t_bad_p1();
        logic [7:0] b;
        b = good_pid(6'h3C) ^ 8'h80;
        step(1, 0, 8'h00, 0);
        step(0, 1, b, 0);
        chk(pid_err == 1'b1, "R5 bad P1", pid_err, 1);
        step(0, 0, 8'h00, 1);
        chk(pid_err == 1'b0, "R9 clear after P1", pid_err, 0);
    endtask

    task automatic t_later_bytes();
        logic [7:0] bad;
        bad = good_pid(6'h07) ^ 8'hC0;
        step(1, 0, 8'h00, 0);
        step(0, 1, good_pid(6'h07), 0);
        step(0, 1, bad, 0);
        chk(pid_err == 1'b0, "R7 later byte unchecked", pid_err, 0);
        chk(fifo_wr_en && fifo_wr_data == bad, "R2 later byte written", fifo_wr_data, bad);
        step(0, 1, bad ^ 8'h40, 0);
        chk(pid_err == 1'b0, "R7 third byte unchecked", pid_err, 0);
    endtask

    task automatic t_collision();
        logic [7:0] bad;
        bad = good_pid(6'h21) ^ 8'h40;
        step(1, 0, 8'h00, 0);
        step(0, 1, bad, 0);
        chk(pid_err == 1'b1, "R6 set before collision", pid_err, 1);
        step(1, 0, 8'h00, 0);
        step(0, 1, bad, 1);
        chk(pid_err == 1'b1, "R10 set beats clear", pid_err, 1);
        step(0, 0, 8'h00, 1);
        chk(pid_err == 1'b0, "R9 clear after collision", pid_err, 0);
    endtask

    task automatic t_sync_same();
        logic [7:0] bad;
        bad = good_pid(6'h33) ^ 8'h80;
        step(1, 1, bad, 0);
        chk(pid_err == 1'b0, "R11 sync-cycle byte unchecked", pid_err, 0);
        chk(fifo_wr_en && fifo_wr_data == bad, "R11 sync-cycle byte written", fifo_wr_data, bad);
        chk(fifo_ptr_rst == 1'b1, "R3 ptr_rst with byte", fifo_ptr_rst, 1);
        step(0, 1, bad, 0);
        chk(pid_err == 1'b1, "R11 next byte checked", pid_err, 1);
        step(0, 0, 8'h00, 1);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 64; i++) begin
            step(1, 0, 8'h00, 0);
            step(0, 1, good_pid(6'(i)), 0);
            chk(pid_err == 1'b0, "R4 R5 sweep good", i, 0);
            step(1, 0, 8'h00, 0);
            step(0, 1, good_pid(6'(i)) ^ 8'h40, 0);
            chk(pid_err == 1'b1, "R4 sweep bad P0", i, 1);
            step(0, 0, 8'h00, 1);
            step(1, 0, 8'h00, 0);
            step(0, 1, good_pid(6'(i)) ^ 8'h80, 0);
            chk(pid_err == 1'b1, "R5 sweep bad P1", i, 1);
            step(0, 0, 8'h00, 1);
        end
    endtask

    initial begin
        rst_n     = 1'b0;
        sync_done = 1'b0;
        rx_valid  = 1'b0;
        rx_data   = 8'h00;
        err_clr   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_pid();
        t_bad_p0();
        t_bad_p1();
        t_later_bytes();
        t_collision();
        t_sync_same();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule